// File: doc/BRIEF.md
# NAND Flash Strobe Window

A CPU-bus slave that turns software accesses into raw NAND flash bus cycles. One address in its small map is a window with no storage behind it. A read there drives the active-low flash read strobe for a fixed number of clocks and hands the flash data bus to the CPU. A write there drives the CPU write data onto the flash data bus and pulses the active-low flash write strobe for the same length. Command latch, address latch and the busy line are handled by software through general-purpose pins, so this block only generates the data strobes.

A second address holds a small chip-select register. Each bit that software sets pulls one active-low chip-select output low. Software sets a select before a burst of window accesses and clears it afterwards. The remaining addresses have no function and read as zero.

The CPU side holds `cpuSel` with a stable address, direction and write data until it samples `cpuReady` high at a clock edge. It then drops `cpuSel` within one cycle.

Top module: `nand_window`

## Requirements
- R1: While and right after reset, `flashRdN` and `flashWrN` are high, `flashCeN` is all ones, `flashDoe` is 0 and `cpuReady` is 0.
- R2: A read at offset 0 holds `flashRdN` low for exactly STROBE_CYC cycles while `flashWrN` stays high. `cpuRdata` then returns the `flashDin` value present in the last strobe cycle.
- R3: A write at offset 0 holds `flashWrN` low for exactly STROBE_CYC cycles while `flashRdN` stays high. `flashDout` carries `cpuWdata` throughout.
- R4: `flashDoe` is 1 exactly in the cycles where `flashWrN` is low, and `flashDout` is 0 whenever `flashDoe` is 0.
- R5: Offsets 1 and 3 read as 00h. A write to them produces no strobe and leaves the chip-select register and `flashCeN` unchanged.
- R6: Writing offset 2 stores `cpuWdata[1:0]`. Bit i set drives `flashCeN[i]` low, and a read of offset 2 returns the stored bits with the upper bits zero.
- R7: `cpuReady` is a one-cycle pulse. It comes STROBE_CYC+1 cycles after a window request is accepted and one cycle after a register request. It is never high while a strobe is active, and a `cpuSel` still high in the ready cycle starts no second access.
- R8: `flashRdN` and `flashWrN` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 1 | Access request, held until ready |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Offset: 0 window, 2 chip-select register, others reserved |
| cpuWdata | input | DATA_W | CPU write data |
| cpuRdata | output | DATA_W | Read data, valid while cpuReady is high, else 0 |
| cpuReady | output | 1 | One-cycle access-complete pulse |
| flashDin | input | DATA_W | Data bus from the flash |
| flashDout | output | DATA_W | Data bus toward the flash |
| flashDoe | output | 1 | Output enable for flashDout |
| flashRdN | output | 1 | Active-low read strobe |
| flashWrN | output | 1 | Active-low write strobe |
| flashCeN | output | CS_W | Active-low chip selects |

## Verification
Two events can meet in one cycle: the ready pulse that ends an access, and a still-asserted request. That request could be read as a new access. The bench keeps `cpuSel` high through the ready cycle of every access and issues the next request straight after. The scoreboard then compares the strobe length counted for each access with the expected value, so a second strobe or a merged strobe shows up as a length mismatch. Latency is checked against the cycle count from request to ready.

// File: rtl/nand_window_pkg.sv
package nand_window_pkg;

  typedef enum logic [1:0] {
    NW_IDLE   = 2'd0,
    NW_STROBE = 2'd1,
    NW_DONE   = 2'd2
  } nwState_t;

  typedef struct packed {
    logic rdStrobe;
    logic wrStrobe;
    logic capture;
    logic regLoad;
    logic ctrlWrite;
    logic ready;
  } nwStrobes_t;

endpackage

// File: rtl/nand_window_ctrl.sv
module nand_window_ctrl
  import nand_window_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int STROBE_CYC = 3,
  parameter logic [ADDR_W-1:0] WIN_OFF  = '0,
  parameter logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  output nwStrobes_t        st
);

  localparam int CNT_W = $clog2(STROBE_CYC + 1);

  nwState_t         state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             hitWin;

  assign hitWin = (cpuAddr == WIN_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= NW_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        NW_IDLE: begin
          if (cpuSel) begin
            if (hitWin) begin
              state   <= NW_STROBE;
              cnt     <= CNT_W'(STROBE_CYC - 1);
              isWrite <= cpuWr;
            end else begin
              state <= NW_DONE;
            end
          end
        end
        NW_STROBE: begin
          if (cnt == '0) state <= NW_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= NW_IDLE;
      endcase
    end
  end

  always_comb begin
    st           = '0;
    st.rdStrobe  = (state == NW_STROBE) && !isWrite;
    st.wrStrobe  = (state == NW_STROBE) && isWrite;
    st.capture   = (state == NW_STROBE) && !isWrite && (cnt == '0);
    st.regLoad   = (state == NW_IDLE) && cpuSel && !hitWin && !cpuWr;
    st.ctrlWrite = (state == NW_IDLE) && cpuSel && (cpuAddr == CTRL_OFF) && cpuWr;
    st.ready     = (state == NW_DONE);
  end

  // R8: the two flash strobes are mutually exclusive
  assert_no_dual_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(st.rdStrobe && st.wrStrobe));

  // R7: ready lasts one cycle
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.ready |=> !st.ready);

  // R7: the end of a read strobe is immediately followed by ready
  assert_ready_follows_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(st.rdStrobe) |-> st.ready);

endmodule

// File: rtl/nand_window_dp.sv
module nand_window_dp
  import nand_window_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CS_W   = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  nwStrobes_t        st,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] flashDin,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashDoe,
  output logic              flashRdN,
  output logic              flashWrN,
  output logic [CS_W-1:0]   flashCeN
);

  localparam int PAD_W = DATA_W - CS_W;

  logic [CS_W-1:0]   csReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csReg <= '0;
      rdReg <= '0;
    end else begin
      if (st.ctrlWrite) csReg <= cpuWdata[CS_W-1:0];
      if (st.capture) begin
        rdReg <= flashDin;
      end else if (st.regLoad) begin
        rdReg <= (cpuAddr == CTRL_OFF) ? {{PAD_W{1'b0}}, csReg} : '0;
      end
    end
  end

  assign cpuRdata  = st.ready ? rdReg : '0;
  assign flashDoe  = st.wrStrobe;
  assign flashDout = st.wrStrobe ? cpuWdata : '0;
  assign flashRdN  = ~st.rdStrobe;
  assign flashWrN  = ~st.wrStrobe;
  assign flashCeN  = ~csReg;

  // R6: chip-select state moves only on a register write
  assert_cs_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !st.ctrlWrite |=> $stable(csReg));

  // R2: read data reflects the flash bus seen on the last strobe cycle
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |=> (rdReg == $past(flashDin)));

endmodule

// File: rtl/nand_window.sv
module nand_window
  import nand_window_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int CS_W       = 2,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  input  logic [DATA_W-1:0] flashDin,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashDoe,
  output logic              flashRdN,
  output logic              flashWrN,
  output logic [CS_W-1:0]   flashCeN
);

  localparam logic [ADDR_W-1:0] WIN_OFF  = '0;
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(2);

  nwStrobes_t st;

  nand_window_ctrl #(
    .ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC),
    .WIN_OFF(WIN_OFF), .CTRL_OFF(CTRL_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .st(st)
  );

  nand_window_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_W(CS_W), .CTRL_OFF(CTRL_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .flashDin(flashDin), .cpuRdata(cpuRdata),
    .flashDout(flashDout), .flashDoe(flashDoe), .flashRdN(flashRdN),
    .flashWrN(flashWrN), .flashCeN(flashCeN)
  );

  assign cpuReady = st.ready;

endmodule

// File: tb/nand_window_bench.sv
`timescale 1ns/1ps
module nand_window_bench;

  localparam int SC = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuSel = 1'b0, cpuWr = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, flashDin = '0;
  logic [7:0] cpuRdata, flashDout;
  logic       cpuReady, flashDoe, flashRdN, flashWrN;
  logic [1:0] flashCeN;

  always #2.5 clk = ~clk;

  nand_window u_nand_window (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .flashDin(flashDin), .flashDout(flashDout),
    .flashDoe(flashDoe), .flashRdN(flashRdN), .flashWrN(flashWrN),
    .flashCeN(flashCeN)
  );

  typedef struct {
    string tag;
    bit    chkData;
    int    rdata;
    int    rdLen;
    int    wrLen;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0, errors = 0;
  bit  finished = 0;
  int  rdLow = 0, wrLow = 0;
  bit  doeBad = 0, dualBad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (!flashRdN) rdLow++;
      if (!flashWrN) wrLow++;
      if (flashDoe !== !flashWrN) doeBad = 1;
      if (flashDoe && flashDout !== cpuWdata) doeBad = 1;
      if (!flashDoe && flashDout !== 8'h00) doeBad = 1;
      if (!flashRdN && !flashWrN) dualBad = 1;
      if (cpuReady) begin
        if (expQ.size() == 0) begin
          chk(0, "R7 unexpected ready", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(rdLow == e.rdLen, {e.tag, " R2 read strobe length"}, rdLow, e.rdLen);
          chk(wrLow == e.wrLen, {e.tag, " R3 write strobe length"}, wrLow, e.wrLen);
          chk(!doeBad, {e.tag, " R4 output enable / data"}, int'(doeBad), 0);
          chk(!dualBad, {e.tag, " R8 dual strobe"}, int'(dualBad), 0);
          if (e.chkData)
            chk(int'(cpuRdata) == e.rdata, {e.tag, " read data"}, int'(cpuRdata), e.rdata);
        end
        rdLow = 0; wrLow = 0; doeBad = 0; dualBad = 0;
      end
    end
  end

  task automatic access(input logic [1:0] addr, input bit wr, input logic [7:0] wd,
                        input bit chkData, input int expRd, input string tag);
    expItem_t e;
    int waits;
    bit win;
    win = (addr == 2'd0);
    e.tag = tag; e.chkData = chkData; e.rdata = expRd;
    e.rdLen = (win && !wr) ? SC : 0;
    e.wrLen = (win && wr) ? SC : 0;
    expQ.push_back(e);
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = wr; cpuAddr = addr; cpuWdata = wd;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!cpuReady && waits < 50);
    // R7: latency from request to ready
    chk(waits == (win ? SC + 1 : 1), {tag, " R7 latency"}, waits, win ? SC + 1 : 1);
    // keep the request up through the ready cycle; drop it one cycle later
    @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0; cpuWdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while in reset
    chk(flashRdN && flashWrN, "R1 strobes in reset", {flashRdN, flashWrN}, 3);
    chk(flashCeN == 2'b11, "R1 chip selects in reset", flashCeN, 3);
    chk(!flashDoe && !cpuReady, "R1 enable/ready in reset", {flashDoe, cpuReady}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(flashRdN && flashWrN && !cpuReady && flashCeN == 2'b11,
        "R1 idle after reset", {flashRdN, flashWrN, cpuReady, flashCeN}, 5'b11011);

    // R6: select chip 0
    access(2'd2, 1, 8'hFD, 0, 0, "R6 cs write 01");
    chk(flashCeN == 2'b10, "R6 ceN after 01", flashCeN, 2'b10);

    // R3: window writes
    access(2'd0, 1, 8'hA5, 0, 0, "R3 write A5");
    access(2'd0, 1, 8'h3C, 0, 0, "R3 write 3C");

    // R2: window reads
    flashDin = 8'h5A;
    access(2'd0, 0, 8'h00, 1, 8'h5A, "R2 read 5A");
    flashDin = 8'hC3;
    access(2'd0, 0, 8'h00, 1, 8'hC3, "R2 read C3");

    // R6: readback
    access(2'd2, 0, 8'h00, 1, 8'h01, "R6 cs read");

    // R5: reserved offsets
    access(2'd1, 0, 8'h00, 1, 8'h00, "R5 read off1");
    access(2'd3, 0, 8'h00, 1, 8'h00, "R5 read off3");
    access(2'd1, 1, 8'hFF, 0, 0, "R5 write off1");
    chk(flashCeN == 2'b10, "R5 ceN unchanged", flashCeN, 2'b10);
    access(2'd2, 0, 8'h00, 1, 8'h01, "R5 cs kept");

    // R6: both selects, then none
    access(2'd2, 1, 8'h03, 0, 0, "R6 cs write 11");
    chk(flashCeN == 2'b00, "R6 ceN after 11", flashCeN, 2'b00);
    access(2'd2, 0, 8'h00, 1, 8'h03, "R6 cs read 11");
    access(2'd2, 1, 8'h00, 0, 0, "R6 cs write 00");
    chk(flashCeN == 2'b11, "R6 ceN after 00", flashCeN, 2'b11);

    // R7: back-to-back mixed accesses, request held through ready
    for (int i = 0; i < 6; i++) begin
      flashDin = 8'(8'h11 * (i + 1));
      if (i % 2 == 0)
        access(2'd0, 0, 8'h00, 1, 8'h11 * (i + 1), "R7 back-to-back read");
      else
        access(2'd0, 1, 8'(8'h80 | i), 0, 0, "R7 back-to-back write");
    end

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R7 pending items", expQ.size(), 0);
    chk(rdLow == 0 && wrLow == 0, "R7 no stray strobe", rdLow + wrLow, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule